// File: doc/BRIEF.md
# Broadcast-PC SIMD Array Cell

This block is one processing cell of an 8x8 array. The cell has no program counter of its own. A global controller sends the same 5-bit program counter to every cell each cycle. Each cell then fetches the entry at that index from its own 32-entry instruction store and executes it.

Each cell has a 16-bit datapath. It contains eight general registers, four input registers, one output register that its neighbours can read, and a 16-entry scratch RAM. Operands can come from:
- the local registers,
- a sign-extended immediate,
- the output registers of the four adjacent cells.

Words can also be captured from a shared row bus and a shared column bus. Each of these buses is 32 bits wide and is split into two 16-bit lanes.

The instruction store is filled through a configuration write port. This port is locked out while the array is executing. When execution is disabled, the cell issues no-operations and holds all of its state.

Top module: `simd_cell`

## Requirements
- R1: After reset, `dout` is 0, and `rowLaneEn` and `colLaneEn` are both 2'b00.
- R2: A configuration write (`cfgWe`) stores `cfgData` at `cfgAddr` only while `execEn` is low. A write attempted while `execEn` is high leaves the stored entry unchanged.
- R3: The entry indexed by `pc` is latched into the instruction register at the next clock edge, and it is executed in the following cycle. Its register results, including the new `dout`, appear after the second edge that follows the cycle in which `pc` was presented.
- R4: The instruction word layout is `{op[31:28], dst[27:24], selA[23:20], selB[19:16], bImm[15], drive[14:12], cap[11:6], imm[5:0]}`. The op codes are:
  - 0 no-op
  - 1 add
  - 2 subtract (A-B)
  - 3 AND
  - 4 OR
  - 5 XOR
  - 6 shift left of A by B[3:0]
  - 7 logical shift right of A by B[3:0]
  - 8 pass A
  - 9 load from RAM
  - 10 store to RAM
  - 11 pass B
  - 12 to 15 behave as no-op

  All arithmetic wraps modulo 2^16.
- R5: Operand select codes are 0-7 for general register 0-7 and 8-11 for input register 0-3. Codes 12, 13, 14 and 15 select the up, down, left and right neighbour respectively. When `bImm` is 1, operand B is `imm` sign-extended to 16 bits.
- R6: Destination codes 0-7 write a general register, and code 8 writes the output register. Any other destination code writes nothing.
- R7: Bits `drive[14:12]` are {enable, 1 = column bus / 0 = row bus, 1 = upper lane / 0 = lower lane}. When enabled, the selected lane enable is raised and the current output register value is presented on that lane, during the cycle in which the instruction executes. All other lane enables stay 0.
- R8: The capture field is `cap` = {enable[11], source[10:8], index[7:6]}. Source 0 captures the row bus and source 1 captures the column bus. Both write an input register pair: index bit 1 = 0 selects pair 0/1, and index bit 1 = 1 selects pair 2/3. Bus bits [15:0] go to the lower-numbered register of the pair and bits [31:16] to the higher-numbered one. The capture takes the bus value present in the executing cycle.
- R9: Capture sources 2 (the cell's own output register) and 3, 4, 5, 6 (up, down, left, right neighbour) load input register `index`. Capturing the own output register reads the value from before any write made in the same cycle.
- R10: Op 10 writes operand A to RAM address imm[3:0], and op 9 returns the word stored at imm[3:0].
- R11: While `execEn` is low, the instruction register holds a no-op, so no register, RAM or bus output changes, whatever `pc` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| execEn | input | 1 | Execute enable; locks out configuration writes |
| pc | input | 5 | Broadcast program counter |
| cfgWe | input | 1 | Instruction store write strobe |
| cfgAddr | input | 5 | Instruction store write address |
| cfgData | input | 32 | Instruction word to store |
| nbrUp | input | 16 | Output register of the upper neighbour |
| nbrDown | input | 16 | Output register of the lower neighbour |
| nbrLeft | input | 16 | Output register of the left neighbour |
| nbrRight | input | 16 | Output register of the right neighbour |
| rowBusIn | input | 32 | Row bus value as resolved by the array |
| colBusIn | input | 32 | Column bus value as resolved by the array |
| rowBusOut | output | 32 | Output register copied onto both row lanes |
| rowLaneEn | output | 2 | Row lane drive enables {upper, lower} |
| colBusOut | output | 32 | Output register copied onto both column lanes |
| colLaneEn | output | 2 | Column lane drive enables {upper, lower} |
| dout | output | 16 | Output register, read by the neighbours |

## Verification
A program counter presented in cycle t has its instruction fetched at the edge that ends cycle t. Its register, RAM and `dout` results land at the following edge. The bench therefore samples `dout` two edges after the last `pc` it presents, and for the latency check it also samples one edge after, when the old value must still be there. Bus lane enables are combinational from the instruction register, so the bench samples them one edge after presenting `pc`, in the middle of the executing cycle. Input-register and RAM contents are not visible at the ports, so the bench routes them to `dout` with a pass or load instruction and checks them two edges later.

// File: rtl/cell_pkg.sv
package cell_pkg;

  localparam int CELL_W   = 16;
  localparam int BUS_W    = 2 * CELL_W;
  localparam int INSTR_W  = 32;
  localparam int NUM_GPR  = 8;
  localparam int NUM_INR  = 4;
  localparam int RAM_AW   = 4;
  localparam int IMM_W    = 6;
  localparam int GPR_AW   = $clog2(NUM_GPR);
  localparam int INR_AW   = $clog2(NUM_INR);

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_ADD   = 4'd1,
    OP_SUB   = 4'd2,
    OP_AND   = 4'd3,
    OP_OR    = 4'd4,
    OP_XOR   = 4'd5,
    OP_SHL   = 4'd6,
    OP_SHR   = 4'd7,
    OP_PASSA = 4'd8,
    OP_LDM   = 4'd9,
    OP_STM   = 4'd10,
    OP_PASSB = 4'd11
  } aluOp_e;

  typedef enum logic [2:0] {
    CAP_ROW   = 3'd0,
    CAP_COL   = 3'd1,
    CAP_SELF  = 3'd2,
    CAP_UP    = 3'd3,
    CAP_DOWN  = 3'd4,
    CAP_LEFT  = 3'd5,
    CAP_RIGHT = 3'd6,
    CAP_RSVD  = 3'd7
  } capSrc_e;

  // strobes passed from decode to the datapath
  typedef struct packed {
    aluOp_e              op;
    logic                gprWe;
    logic [GPR_AW-1:0]   gprIdx;
    logic                outWe;
    logic                ramWe;
    logic [RAM_AW-1:0]   ramAddr;
    logic [3:0]          selA;
    logic [3:0]          selB;
    logic                bImm;
    logic [CELL_W-1:0]   immVal;
    logic                driveEn;
    logic                driveCol;
    logic                driveHi;
    logic                capEn;
    capSrc_e             capSrc;
    logic [INR_AW-1:0]   capIdx;
  } cellCtl_t;

endpackage

// File: rtl/cell_imem.sv
module cell_imem
  import cell_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               execEn,
  input  logic [AW-1:0]      rdAddr,
  output logic [INSTR_W-1:0] rdData,
  input  logic               cfgWe,
  input  logic [AW-1:0]      cfgAddr,
  input  logic [INSTR_W-1:0] cfgData
);

  logic [INSTR_W-1:0] mem [DEPTH];

  // configuration writes are only honoured while the array is stopped
  always_ff @(posedge clk) begin
    if (cfgWe && !execEn) begin
      mem[cfgAddr] <= cfgData;
    end
  end

  assign rdData = mem[rdAddr];

  // every entry holds still across a cycle in which execution was enabled
  for (genvar g = 0; g < DEPTH; g++) begin : gLock
    p_cfg_locked_r2 : assert property (@(posedge clk) disable iff (!rstN)
      execEn |=> $stable(mem[g]));
  end

endmodule

// File: rtl/cell_ctrl.sv
module cell_ctrl
  import cell_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               execEn,
  input  logic [INSTR_W-1:0] fetchWord,
  output cellCtl_t           ctl
);

  logic [INSTR_W-1:0] instrQ;

  // instruction register: a no-op is loaded whenever execution is off
  always_ff @(posedge clk) begin
    if (!rstN) begin
      instrQ <= '0;
    end else if (execEn) begin
      instrQ <= fetchWord;
    end else begin
      instrQ <= '0;
    end
  end

  logic [3:0]       fOp;
  logic [3:0]       fDst;
  logic [2:0]       fDrive;
  logic [5:0]       fCap;
  logic [IMM_W-1:0] fImm;
  logic             writesResult;

  assign fOp    = instrQ[31:28];
  assign fDst   = instrQ[27:24];
  assign fDrive = instrQ[14:12];
  assign fCap   = instrQ[11:6];
  assign fImm   = instrQ[5:0];

  always_comb begin
    ctl = '0;
    writesResult = 1'b0;
    unique case (fOp)
      4'd1:  ctl.op = OP_ADD;
      4'd2:  ctl.op = OP_SUB;
      4'd3:  ctl.op = OP_AND;
      4'd4:  ctl.op = OP_OR;
      4'd5:  ctl.op = OP_XOR;
      4'd6:  ctl.op = OP_SHL;
      4'd7:  ctl.op = OP_SHR;
      4'd8:  ctl.op = OP_PASSA;
      4'd9:  ctl.op = OP_LDM;
      4'd10: ctl.op = OP_STM;
      4'd11: ctl.op = OP_PASSB;
      default: ctl.op = OP_NOP;
    endcase
    writesResult = (ctl.op != OP_NOP) && (ctl.op != OP_STM);
    ctl.gprWe    = writesResult && !fDst[3];
    ctl.gprIdx   = fDst[GPR_AW-1:0];
    ctl.outWe    = writesResult && (fDst == 4'd8);
    ctl.ramWe    = (ctl.op == OP_STM);
    ctl.ramAddr  = fImm[RAM_AW-1:0];
    ctl.selA     = instrQ[23:20];
    ctl.selB     = instrQ[19:16];
    ctl.bImm     = instrQ[15];
    ctl.immVal   = {{(CELL_W-IMM_W){fImm[IMM_W-1]}}, fImm};
    ctl.driveEn  = fDrive[2];
    ctl.driveCol = fDrive[1];
    ctl.driveHi  = fDrive[0];
    ctl.capEn    = fCap[5] && (fCap[4:2] != CAP_RSVD);
    ctl.capSrc   = capSrc_e'(fCap[4:2]);
    ctl.capIdx   = fCap[1:0];
  end

  // a stopped array issues nothing with a side effect in the next cycle
  p_idle_quiet_r11 : assert property (@(posedge clk) disable iff (!rstN)
    !execEn |=> !(ctl.gprWe || ctl.outWe || ctl.ramWe || ctl.capEn || ctl.driveEn));

endmodule

// File: rtl/cell_datapath.sv
module cell_datapath
  import cell_pkg::*;
#(
  parameter int RAM_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  cellCtl_t          ctl,
  input  logic [CELL_W-1:0] nbrUp,
  input  logic [CELL_W-1:0] nbrDown,
  input  logic [CELL_W-1:0] nbrLeft,
  input  logic [CELL_W-1:0] nbrRight,
  input  logic [BUS_W-1:0]  rowBusIn,
  input  logic [BUS_W-1:0]  colBusIn,
  output logic [BUS_W-1:0]  rowBusOut,
  output logic [1:0]        rowLaneEn,
  output logic [BUS_W-1:0]  colBusOut,
  output logic [1:0]        colLaneEn,
  output logic [CELL_W-1:0] outReg
);

  logic [CELL_W-1:0] gpr     [NUM_GPR];
  logic [CELL_W-1:0] inReg   [NUM_INR];
  logic [CELL_W-1:0] scratch [RAM_DEPTH];
  logic [CELL_W-1:0] opA, opB, result;
  logic [3:0]        shAmt;

  function automatic logic [CELL_W-1:0] pickSrc(
    input logic [3:0] sel,
    input logic [CELL_W-1:0] g [NUM_GPR],
    input logic [CELL_W-1:0] d [NUM_INR],
    input logic [CELL_W-1:0] up, dn, lf, rt
  );
    if (!sel[3])              return g[sel[2:0]];
    else if (sel[3:2] == 2'b10) return d[sel[1:0]];
    else begin
      case (sel[1:0])
        2'd0:    return up;
        2'd1:    return dn;
        2'd2:    return lf;
        default: return rt;
      endcase
    end
  endfunction

  assign opA   = pickSrc(ctl.selA, gpr, inReg, nbrUp, nbrDown, nbrLeft, nbrRight);
  assign opB   = ctl.bImm ? ctl.immVal
                          : pickSrc(ctl.selB, gpr, inReg, nbrUp, nbrDown, nbrLeft, nbrRight);
  assign shAmt = opB[3:0];

  always_comb begin
    unique case (ctl.op)
      OP_ADD:   result = opA + opB;
      OP_SUB:   result = opA - opB;
      OP_AND:   result = opA & opB;
      OP_OR:    result = opA | opB;
      OP_XOR:   result = opA ^ opB;
      OP_SHL:   result = opA << shAmt;
      OP_SHR:   result = opA >> shAmt;
      OP_PASSA: result = opA;
      OP_PASSB: result = opB;
      OP_LDM:   result = scratch[ctl.ramAddr];
      default:  result = '0;
    endcase
  end

  // general registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_GPR; i++) gpr[i] <= '0;
    end else if (ctl.gprWe) begin
      gpr[ctl.gprIdx] <= result;
    end
  end

  // output register seen by the neighbours and the buses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg <= '0;
    end else if (ctl.outWe) begin
      outReg <= result;
    end
  end

  // scratch RAM
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < RAM_DEPTH; i++) scratch[i] <= '0;
    end else if (ctl.ramWe) begin
      scratch[ctl.ramAddr] <= opA;
    end
  end

  // input registers: bus words land in a pair, other sources in one slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_INR; i++) inReg[i] <= '0;
    end else if (ctl.capEn) begin
      case (ctl.capSrc)
        CAP_ROW, CAP_COL: begin
          if (ctl.capIdx[1]) begin
            inReg[2] <= (ctl.capSrc == CAP_ROW) ? rowBusIn[CELL_W-1:0] : colBusIn[CELL_W-1:0];
            inReg[3] <= (ctl.capSrc == CAP_ROW) ? rowBusIn[BUS_W-1:CELL_W] : colBusIn[BUS_W-1:CELL_W];
          end else begin
            inReg[0] <= (ctl.capSrc == CAP_ROW) ? rowBusIn[CELL_W-1:0] : colBusIn[CELL_W-1:0];
            inReg[1] <= (ctl.capSrc == CAP_ROW) ? rowBusIn[BUS_W-1:CELL_W] : colBusIn[BUS_W-1:CELL_W];
          end
        end
        CAP_SELF:  inReg[ctl.capIdx] <= outReg;
        CAP_UP:    inReg[ctl.capIdx] <= nbrUp;
        CAP_DOWN:  inReg[ctl.capIdx] <= nbrDown;
        CAP_LEFT:  inReg[ctl.capIdx] <= nbrLeft;
        CAP_RIGHT: inReg[ctl.capIdx] <= nbrRight;
        default: ;
      endcase
    end
  end

  // bus drive: the output register goes on one lane of one bus
  logic [1:0] laneSel;
  assign laneSel   = ctl.driveHi ? 2'b10 : 2'b01;
  assign rowLaneEn = (ctl.driveEn && !ctl.driveCol) ? laneSel : 2'b00;
  assign colLaneEn = (ctl.driveEn &&  ctl.driveCol) ? laneSel : 2'b00;
  assign rowBusOut = {outReg, outReg};
  assign colBusOut = {outReg, outReg};

  p_one_lane_r7 : assert property (@(posedge clk) disable iff (!rstN)
    $countones({rowLaneEn, colLaneEn}) <= 1);

endmodule

// File: rtl/simd_cell.sv
module simd_cell
  import cell_pkg::*;
#(
  parameter int IMEM_DEPTH = 32,
  parameter int RAM_DEPTH  = 16,
  localparam int PC_W      = $clog2(IMEM_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               execEn,
  input  logic [PC_W-1:0]    pc,
  input  logic               cfgWe,
  input  logic [PC_W-1:0]    cfgAddr,
  input  logic [INSTR_W-1:0] cfgData,
  input  logic [CELL_W-1:0]  nbrUp,
  input  logic [CELL_W-1:0]  nbrDown,
  input  logic [CELL_W-1:0]  nbrLeft,
  input  logic [CELL_W-1:0]  nbrRight,
  input  logic [BUS_W-1:0]   rowBusIn,
  input  logic [BUS_W-1:0]   colBusIn,
  output logic [BUS_W-1:0]   rowBusOut,
  output logic [1:0]         rowLaneEn,
  output logic [BUS_W-1:0]   colBusOut,
  output logic [1:0]         colLaneEn,
  output logic [CELL_W-1:0]  dout
);

  logic [INSTR_W-1:0] fetchWord;
  cellCtl_t           ctl;

  cell_imem #(.DEPTH(IMEM_DEPTH)) uImem (
    .clk     (clk),
    .rstN    (rstN),
    .execEn  (execEn),
    .rdAddr  (pc),
    .rdData  (fetchWord),
    .cfgWe   (cfgWe),
    .cfgAddr (cfgAddr),
    .cfgData (cfgData)
  );

  cell_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .execEn    (execEn),
    .fetchWord (fetchWord),
    .ctl       (ctl)
  );

  cell_datapath #(.RAM_DEPTH(RAM_DEPTH)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .nbrUp     (nbrUp),
    .nbrDown   (nbrDown),
    .nbrLeft   (nbrLeft),
    .nbrRight  (nbrRight),
    .rowBusIn  (rowBusIn),
    .colBusIn  (colBusIn),
    .rowBusOut (rowBusOut),
    .rowLaneEn (rowLaneEn),
    .colBusOut (colBusOut),
    .colLaneEn (colLaneEn),
    .outReg    (dout)
  );

  // stopping execution freezes the output register one cycle later
  p_out_hold_r11 : assert property (@(posedge clk) disable iff (!rstN)
    !execEn |=> ##1 $stable(dout));

endmodule

// File: tb/tb_simd_cell.sv
`timescale 1ns/1ps
module tb_simd_cell;

  logic        clk = 1'b0;
  logic        rstN;
  logic        execEn;
  logic [4:0]  pc;
  logic        cfgWe;
  logic [4:0]  cfgAddr;
  logic [31:0] cfgData;
  logic [15:0] nbrUp, nbrDown, nbrLeft, nbrRight;
  logic [31:0] rowBusIn, colBusIn, rowBusOut, colBusOut;
  logic [1:0]  rowLaneEn, colLaneEn;
  logic [15:0] dout;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit ended   = 0;

  always #2.5 clk = ~clk;

  simd_cell dut (
    .clk(clk), .rstN(rstN), .execEn(execEn), .pc(pc),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .nbrUp(nbrUp), .nbrDown(nbrDown), .nbrLeft(nbrLeft), .nbrRight(nbrRight),
    .rowBusIn(rowBusIn), .colBusIn(colBusIn),
    .rowBusOut(rowBusOut), .rowLaneEn(rowLaneEn),
    .colBusOut(colBusOut), .colLaneEn(colLaneEn),
    .dout(dout)
  );

  // op codes and selector codes as given in the requirements
  localparam logic [3:0] NOP=0, ADD=1, SUB=2, AND_=3, OR_=4, XOR_=5, SHL=6, SHR=7,
                         PSA=8, LDM=9, STM=10, PSB=11;
  localparam logic [3:0] OUTR = 4'd8, NONE = 4'd9;

  function automatic logic [31:0] ins(input logic [3:0] op, dst, sa, sb,
                                      input logic bi, input logic [2:0] drv,
                                      input logic [5:0] cap, input logic [5:0] imm);
    return {op, dst, sa, sb, bi, drv, cap, imm};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic put(input int addr, input logic [31:0] w);
    execEn = 0; cfgWe = 1; cfgAddr = addr[4:0]; cfgData = w;
    tick();
    cfgWe = 0;
  endtask

  // present start..start+n-1, then stop; dout is final after the extra edge
  task automatic run(input int start, input int n);
    execEn = 1;
    for (int i = 0; i < n; i++) begin
      pc = 5'(start + i);
      tick();
    end
    execEn = 0;
    tick();
    tick();
  endtask

  task automatic t_reset();
    chk("R1 dout", dout, 0);
    chk("R1 row lanes", rowLaneEn, 0);
    chk("R1 col lanes", colLaneEn, 0);
  endtask

  task automatic t_alu();
    logic [31:0] w [10];
    logic [15:0] e [10];
    put(0, ins(PSB, 4'd0, 0, 0, 1, 0, 0, 6'd25));
    put(1, ins(PSB, 4'd1, 0, 0, 1, 0, 0, 6'h3D));
    w[0] = ins(ADD, OUTR, 0, 1, 0, 0, 0, 0);  e[0] = 16'd22;
    w[1] = ins(SUB, OUTR, 0, 1, 0, 0, 0, 0);  e[1] = 16'd28;
    w[2] = ins(AND_, OUTR, 0, 1, 0, 0, 0, 0); e[2] = 16'h0019;
    w[3] = ins(OR_, OUTR, 0, 1, 0, 0, 0, 0);  e[3] = 16'hFFFD;
    w[4] = ins(XOR_, OUTR, 0, 1, 0, 0, 0, 0); e[4] = 16'hFFE4;
    w[5] = ins(SHL, OUTR, 0, 0, 1, 0, 0, 6'd4); e[5] = 16'h0190;
    w[6] = ins(SHR, OUTR, 1, 0, 1, 0, 0, 6'd4); e[6] = 16'h0FFF;
    w[7] = ins(ADD, OUTR, 1, 1, 0, 0, 0, 0);  e[7] = 16'hFFFA;
    w[8] = ins(PSA, OUTR, 0, 0, 0, 0, 0, 0);  e[8] = 16'd25;
    w[9] = ins(4'd13, OUTR, 0, 0, 0, 0, 0, 0); e[9] = 16'd25;
    for (int k = 0; k < 10; k++) begin
      put(2, w[k]);
      run(0, 3);
      chk($sformatf("R4 R5 R6 op case %0d", k), dout, e[k]);
    end
    // destination code 9 writes nothing
    put(2, ins(PSB, NONE, 0, 0, 1, 0, 0, 6'd7));
    run(2, 1);
    chk("R6 no-write destination", dout, 16'd25);
  endtask

  task automatic t_neighbour();
    nbrUp = 16'h1111; nbrDown = 16'h2222; nbrLeft = 16'h3333; nbrRight = 16'h4444;
    put(3, ins(ADD, OUTR, 4'd12, 4'd15, 0, 0, 0, 0));
    run(3, 1);
    chk("R5 up+right", dout, 16'h5555);
    put(3, ins(SUB, OUTR, 4'd13, 4'd14, 0, 0, 0, 0));
    run(3, 1);
    chk("R5 down-left", dout, 16'hEEEF);
  endtask

  task automatic t_ram();
    put(4, ins(STM, NONE, 0, 0, 0, 0, 0, 6'd9));
    put(5, ins(PSB, OUTR, 0, 0, 1, 0, 0, 6'd0));
    put(6, ins(LDM, OUTR, 0, 0, 0, 0, 0, 6'd9));
    run(0, 1);
    run(4, 2);
    chk("R10 cleared before load", dout, 0);
    run(6, 1);
    chk("R10 store then load", dout, 16'd25);
  endtask

  task automatic t_dir_single();
    put(7,  ins(PSB, OUTR, 0, 0, 1, 0, 0, 6'd10));
    put(8,  ins(PSB, OUTR, 0, 0, 1, 0, {1'b1, 3'd2, 2'd1}, 6'd0));
    put(9,  ins(PSA, OUTR, 4'd9, 0, 0, 0, 0, 0));
    put(10, ins(NOP, NONE, 0, 0, 0, 0, {1'b1, 3'd5, 2'd0}, 0));
    put(11, ins(PSA, OUTR, 4'd8, 0, 0, 0, 0, 0));
    run(7, 2);
    chk("R9 dout written in capture cycle", dout, 0);
    run(9, 1);
    chk("R9 own output captured before write", dout, 16'd10);
    run(10, 2);
    chk("R9 left neighbour capture", dout, 16'h3333);
  endtask

  task automatic t_bus_capture();
    rowBusIn = 32'hBEEF_1234; colBusIn = 32'hCAFE_5678;
    put(12, ins(NOP, NONE, 0, 0, 0, 0, {1'b1, 3'd0, 2'd2}, 0));
    put(13, ins(NOP, NONE, 0, 0, 0, 0, {1'b1, 3'd1, 2'd0}, 0));
    run(12, 2);
    rowBusIn = 0; colBusIn = 0;
    put(14, ins(PSA, OUTR, 4'd10, 0, 0, 0, 0, 0));
    run(14, 1);
    chk("R8 row pair low half", dout, 16'h1234);
    put(14, ins(PSA, OUTR, 4'd11, 0, 0, 0, 0, 0));
    run(14, 1);
    chk("R8 row pair high half", dout, 16'hBEEF);
    put(14, ins(PSA, OUTR, 4'd8, 0, 0, 0, 0, 0));
    run(14, 1);
    chk("R8 column pair low half", dout, 16'h5678);
    put(14, ins(PSA, OUTR, 4'd9, 0, 0, 0, 0, 0));
    run(14, 1);
    chk("R8 column pair high half", dout, 16'hCAFE);
  endtask

  task automatic t_bus_drive();
    // dout holds 16'hCAFE from the previous scenario
    put(15, ins(NOP, NONE, 0, 0, 0, 3'b111, 0, 0));
    put(16, ins(NOP, NONE, 0, 0, 0, 3'b100, 0, 0));
    execEn = 1; pc = 15;
    tick();
    chk("R7 column upper lane enable", colLaneEn, 2'b10);
    chk("R7 row idle while column drives", rowLaneEn, 2'b00);
    chk("R7 column upper data", colBusOut[31:16], 16'hCAFE);
    pc = 16;
    tick();
    chk("R7 row lower lane enable", rowLaneEn, 2'b01);
    chk("R7 column released", colLaneEn, 2'b00);
    chk("R7 row lower data", rowBusOut[15:0], 16'hCAFE);
    execEn = 0;
    tick();
    chk("R7 R11 lanes off when stopped", {rowLaneEn, colLaneEn}, 4'b0000);
  endtask

  task automatic t_latency();
    put(17, ins(PSB, OUTR, 0, 0, 1, 0, 0, 6'd0));
    put(18, ins(PSB, OUTR, 0, 0, 1, 0, 0, 6'd17));
    run(17, 1);
    execEn = 1; pc = 18;
    tick();
    execEn = 0;
    chk("R3 one edge after pc: unchanged", dout, 0);
    tick();
    chk("R3 two edges after pc: result", dout, 16'd17);
  endtask

  task automatic t_idle();
    put(19, ins(PSB, OUTR, 0, 0, 1, 0, 0, 6'd3));
    execEn = 0; pc = 19;
    tick(); tick(); tick();
    chk("R11 stopped array keeps dout", dout, 16'd17);
    run(19, 1);
    chk("R11 same entry runs when enabled", dout, 16'd3);
  endtask

  task automatic t_cfg_block();
    put(20, ins(PSB, OUTR, 0, 0, 1, 0, 0, 6'd9));
    execEn = 1; pc = 21; cfgWe = 1; cfgAddr = 20;
    cfgData = ins(PSB, OUTR, 0, 0, 1, 0, 0, 6'd20);
    tick();
    cfgWe = 0; execEn = 0;
    tick();
    run(20, 1);
    chk("R2 write during execution ignored", dout, 16'd9);
    put(20, ins(PSB, OUTR, 0, 0, 1, 0, 0, 6'd20));
    run(20, 1);
    chk("R2 write while stopped stored", dout, 16'd20);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !ended) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    rstN = 0; execEn = 0; pc = 0; cfgWe = 0; cfgAddr = 0; cfgData = 0;
    nbrUp = 0; nbrDown = 0; nbrLeft = 0; nbrRight = 0;
    rowBusIn = 0; colBusIn = 0;
    // park unused entries as no-ops
    for (int a = 0; a < 32; a++) begin
      cfgWe = 1; cfgAddr = a[4:0]; cfgData = 0;
      @(posedge clk); #1;
    end
    cfgWe = 0;
    tick(); tick();
    rstN = 1;
    #1;
    t_reset();
    t_alu();
    t_neighbour();
    t_ram();
    t_dir_single();
    t_bus_capture();
    t_bus_drive();
    t_latency();
    t_idle();
    t_cfg_block();
    finish_run();
  end

endmodule